// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Bank Writes

This block is a memory-mapped general-purpose I/O controller. It holds four banks of pins behind a simple single-cycle 32-bit register bus made of an address, a write strobe, write data and registered read data. Each bank stores output data, a per-pin direction and a per-pin output enable. It drives per-pin output values and tri-state enables toward the pads and returns the synchronized live level of every pin.

Output data is normally changed through write-only half-bank registers. One write carries a 16-bit keep-mask in its upper half and 16 data bits in its lower half. Any subset of one half-bank can therefore be changed in a single bus access, with no read-modify-write. Bank 1 has only 22 pins. In bank 0, pins 7 and 8 are fixed as outputs.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every `pin_out` and `pin_oe` bit is 0. The direction register reads 0 in every bank except bank 0, which reads 0x0000_0180 because pins 7 and 8 are outputs.
- R2: A write to the low masked register of bank b, at byte offset 8*b, updates output bit i (0..15) to wdata[i] only where wdata[16+i] is 0. Where wdata[16+i] is 1, the output keeps its value. The new value appears on `pin_out` on the clock after the write edge.
- R3: A write to the high masked register of bank b, at offset 8*b+4, applies the same rule to pins 16..31 of that bank. Data bit i goes to pin 16+i and mask bit 16+i guards it. The low half of the bank is not touched.
- R4: `pin_oe` for a pin is 1 exactly when both its direction bit and its output-enable bit are 1. `pin_out` always carries the stored output data bit.
- R5: The direction register (offset 0x204 + 0x40*b, 1 = output) and the output-enable register (offset 0x208 + 0x40*b, 1 = enabled) are read-write and read back what was written.
- R6: Direction bits 7 and 8 of bank 0 cannot be cleared. Writing 0 to them leaves them at 1.
- R7: Bank 1 implements pins 0..21 only. Bits 22..31 of every bank-1 register read as 0 and ignore writes, and the matching `pin_out` and `pin_oe` bits stay 0.
- R8: The data register at offset 0x060 + 4*b returns the pin levels of bank b through a two-flop synchronizer. With the address held, a level applied before clock edge 1 is still absent from `bus_rdata` after edge 2 and is present after edge 3.
- R9: The masked write registers read as 0. Unmapped offsets, including the interrupt range 0x20C..0x224 and non-word-aligned addresses, read as 0, and writes to them change no state.
- R10: `bus_rdata` is registered. It reflects the address presented at the previous clock edge, not the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, effective at the same clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 128 | Live pin levels, 32 per bank, bank b at bits 32*b+31..32*b |
| pin_out | output | 128 | Output values toward the pads |
| pin_oe | output | 128 | Per-pin drive enables toward the pads |

## Verification
A corrupted output-data bit shows on `pin_out` on the cycle after the faulty write. Keep-mask handling is checked by writing patterns with partial masks and comparing both halves of the bank. A wrong direction or enable bit shows at once on `pin_oe`, and it also shows on the next register read one cycle later. A synchronizer fault appears as a change in read-back latency, which the bench measures edge by edge against the stated three-edge visibility.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W      = 32;
  localparam int HALF_W      = 16;
  localparam int MASK_BASE   = 'h000;
  localparam int MASK_STRIDE = 8;
  localparam int MASK_HI_OFS = 4;
  localparam int DATA_BASE   = 'h060;
  localparam int DATA_STRIDE = 4;
  localparam int DIR_BASE    = 'h204;
  localparam int OE_BASE     = 'h208;
  localparam int CFG_STRIDE  = 'h40;

  function automatic logic [WORD_W-1:0] impl_mask(input int width);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) if (i < width) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs import gpio_bank_pkg::*; #(
  parameter int                PINS   = 32,
  parameter logic [WORD_W-1:0] FORCED = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_dir,
  input  logic              wr_oe,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dout_q,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] oe_q
);
  localparam logic [WORD_W-1:0] IMPL = impl_mask(PINS);
  localparam logic [WORD_W-1:0] DIR_RST = FORCED & IMPL;

  // Output data: per-bit update wherever the keep-mask bit is clear
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else begin
      for (int i = 0; i < HALF_W; i++) begin
        if (wr_lo && !wdata[HALF_W+i]) dout_q[i]        <= wdata[i] & IMPL[i];
        if (wr_hi && !wdata[HALF_W+i]) dout_q[HALF_W+i] <= wdata[i] & IMPL[HALF_W+i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RST;
      oe_q  <= '0;
    end else begin
      if (wr_dir) dir_q <= (wdata | FORCED) & IMPL;
      if (wr_oe)  oe_q  <= wdata & IMPL;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl import gpio_bank_pkg::*; #(
  parameter int                NUM_BANKS   = 4,
  parameter int                ADDR_W      = 12,
  parameter int                NARROW_BANK = 1,
  parameter int                NARROW_PINS = 22,
  parameter logic [WORD_W-1:0] FIXED_OUT0  = 32'h0000_0180
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0] pin_in,
  output logic [NUM_BANKS*WORD_W-1:0] pin_out,
  output logic [NUM_BANKS*WORD_W-1:0] pin_oe
);
  localparam int PINS = NUM_BANKS * WORD_W;

  logic [PINS-1:0] dout_all, dir_all, oe_all, sync_all, impl_all;

  gpio_in_sync #(.N(PINS)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_all)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int                W = (b == NARROW_BANK) ? NARROW_PINS : WORD_W;
      localparam logic [WORD_W-1:0] F = (b == 0) ? FIXED_OUT0 : '0;
      localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(MASK_BASE + b*MASK_STRIDE);
      localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(MASK_BASE + b*MASK_STRIDE + MASK_HI_OFS);
      localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + b*CFG_STRIDE);
      localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(OE_BASE + b*CFG_STRIDE);

      assign impl_all[b*WORD_W +: WORD_W] = impl_mask(W);

      gpio_bank_regs #(.PINS(W), .FORCED(F)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (bus_we && bus_addr == A_LO),
        .wr_hi (bus_we && bus_addr == A_HI),
        .wr_dir(bus_we && bus_addr == A_DIR),
        .wr_oe (bus_we && bus_addr == A_OE),
        .wdata (bus_wdata),
        .dout_q(dout_all[b*WORD_W +: WORD_W]),
        .dir_q (dir_all[b*WORD_W +: WORD_W]),
        .oe_q  (oe_all[b*WORD_W +: WORD_W])
      );
    end
  endgenerate

  // Read mux: masked registers and unmapped offsets fall through to zero
  logic [WORD_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(DATA_BASE + b*DATA_STRIDE))
        rd_next = sync_all[b*WORD_W +: WORD_W] & impl_all[b*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(DIR_BASE + b*CFG_STRIDE))
        rd_next = dir_all[b*WORD_W +: WORD_W];
      if (bus_addr == ADDR_W'(OE_BASE + b*CFG_STRIDE))
        rd_next = oe_all[b*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign pin_out = dout_all;
  assign pin_oe  = dir_all & oe_all;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int PINS   = 128
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   dir_all,
  input logic [PINS-1:0]   impl_all
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0)); // R1

  AST_KEEP_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == '0 && bus_wdata[31:16] == 16'hFFFF)
      |=> pin_out[15:0] == $past(pin_out[15:0])); // R2

  AST_WRITE_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == '0 && bus_wdata[31:16] == 16'h0000)
      |=> pin_out[15:0] == $past(bus_wdata[15:0])); // R2

  AST_FIXED_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    dir_all[8:7] == 2'b11); // R6

  AST_NARROW_IDLE: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~impl_all) == '0) && ((pin_oe & ~impl_all) == '0)); // R7

  AST_IRQ_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) >= ADDR_W'('h20C) && $past(bus_addr) <= ADDR_W'('h224)
     && $past(bus_addr[1:0]) != 2'b00) |-> bus_rdata == '0); // R9
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W), .PINS(PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .dir_all(dir_all), .impl_all(impl_all)
);

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  gpio_bank_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    rd(12'h204, v); check("R1 dir bank0", {96'b0, v}, 128'h180);
    rd(12'h284, v); check("R1 dir bank2", {96'b0, v}, 128'h0);
  endtask

  task automatic t_masked_low;
    wr(12'h000, 32'h0000_A5A5);
    check("R2 full write", {112'b0, pin_out[15:0]}, 128'hA5A5);
    wr(12'h000, 32'hFFF0_000F);
    check("R2 partial mask", {112'b0, pin_out[15:0]}, 128'hA5AF);
    wr(12'h000, 32'hFFFF_0000);
    check("R2 all masked", {112'b0, pin_out[15:0]}, 128'hA5AF);
  endtask

  task automatic t_masked_high;
    wr(12'h014, 32'h0000_1234);
    check("R3 high half", {112'b0, pin_out[80 +: 16]}, 128'h1234);
    check("R3 low half untouched", {112'b0, pin_out[64 +: 16]}, 128'h0);
    wr(12'h014, 32'h7FFF_FFFF);
    check("R3 single pin", {112'b0, pin_out[80 +: 16]}, 128'h9234);
  endtask

  task automatic t_dir_oe;
    logic [31:0] v;
    wr(12'h2C4, 32'h0000_00FF);
    wr(12'h2C8, 32'h0000_0F0F);
    rd(12'h2C4, v); check("R5 dir readback", {96'b0, v}, 128'hFF);
    rd(12'h2C8, v); check("R5 oe readback", {96'b0, v}, 128'h0F0F);
    check("R4 oe gating", {96'b0, pin_oe[96 +: 32]}, 128'h0F);
    wr(12'h018, 32'h0000_FFFF);
    check("R4 out value", {112'b0, pin_out[96 +: 16]}, 128'hFFFF);
  endtask

  task automatic t_fixed;
    logic [31:0] v;
    wr(12'h204, 32'h0);
    rd(12'h204, v); check("R6 dir stuck", {96'b0, v}, 128'h180);
    wr(12'h208, 32'h0000_0180);
    check("R6 pins drive", {126'b0, pin_oe[8:7]}, 128'h3);
  endtask

  task automatic t_narrow;
    logic [31:0] v;
    wr(12'h244, 32'hFFFF_FFFF);
    rd(12'h244, v); check("R7 dir width", {96'b0, v}, 128'h003F_FFFF);
    wr(12'h248, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0000_FFFF);
    check("R7 out width", {96'b0, pin_out[32 +: 32]}, 128'h003F_0000);
    check("R7 oe width", {96'b0, pin_oe[32 +: 32]}, 128'h003F_FFFF);
    pin_in[32 +: 32] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rd(12'h064, v); check("R7 data width", {96'b0, v}, 128'h003F_FFFF);
  endtask

  task automatic t_sync;
    @(negedge clk);
    bus_addr = 12'h068;
    pin_in[64 +: 32] = 32'hCAFE_BABE;
    @(negedge clk);
    @(negedge clk);
    check("R8 not yet visible", {96'b0, bus_rdata}, 128'h0);
    @(negedge clk);
    check("R8 visible", {96'b0, bus_rdata}, 128'hCAFE_BABE);
  endtask

  task automatic t_readzero;
    logic [31:0] v;
    logic [127:0] po, pe;
    rd(12'h000, v); check("R9 masked reads zero", {96'b0, v}, 128'h0);
    rd(12'h210, v); check("R9 irq reads zero", {96'b0, v}, 128'h0);
    po = pin_out; pe = pin_oe;
    wr(12'h210, 32'hFFFF_FFFF);
    wr(12'h2C5, 32'h0000_0000);
    wr(12'h001, 32'h0000_0000);
    check("R9 out unchanged", pin_out, po);
    check("R9 oe unchanged", pin_oe, pe);
    rd(12'h2C4, v); check("R9 dir unchanged", {96'b0, v}, 128'hFF);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    rd(12'h210, v);
    @(negedge clk);
    bus_addr = 12'h2C4;
    #1;
    check("R10 old data held", {96'b0, bus_rdata}, 128'h0);
    @(negedge clk);
    check("R10 new data", {96'b0, bus_rdata}, 128'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked_low();
    t_masked_high();
    t_dir_oe();
    t_fixed();
    t_narrow();
    t_sync();
    t_readzero();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule